// File: doc/BRIEF.md
# Pipelined Pulse Width Measurer

This block watches a single asynchronous digital line and reports how long the line stayed at each level. The line is brought into the clock domain by a flop chain. Every clock cycle, the synchronised level is compared with the level seen one cycle earlier. A free-running tick counter gives each transition a timestamp. Every interval between two consecutive transitions is queued, together with the level the line held during that interval. A downstream consumer drains the queue through a valid/ready port.

The work is split into two pipeline stages. The first stage only compares levels and latches a one-bit transition marker together with its timestamp. In the next cycle, the second stage performs the subtraction and the queue write. Because of this split, comparison runs on every cycle even while an earlier width is still in flight. Intervals as short as one clock are therefore resolved back to back.

If the queue is full when a width is ready, that width is lost and a sticky flag records the loss.

Top module: `pulse_width_meter`

## Requirements
- R1: The input line passes through a two-flop synchronizer. Out of reset, the line is taken to be low.
- R2: After reset, `o_valid` is 0 and `o_overflow` is 0.
- R3: The first transition after reset only records a timestamp and queues no entry.
- R4: Each later transition queues one entry. Its `o_width` equals the number of clock cycles since the preceding transition.
- R5: `o_pol` is 1 when the measured interval was a high level and 0 when it was a low level.
- R6: Consecutive one-cycle intervals are each measured, with width 1 and none lost.
- R7: The width is the timestamp difference modulo 2^TS_W, so a counter wrap between two transitions still gives the true width when that width is below 2^TS_W.
- R8: Entries leave in arrival order. An entry is consumed on a clock where `o_valid` and `i_ready` are both 1. While `o_valid` is 1 and `i_ready` is 0, the entry stays unchanged.
- R9: The queue holds DEPTH (16) entries. A width produced while the queue is full is discarded and sets `o_overflow`.
- R10: `o_overflow` stays set through any later traffic and is cleared only by `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_line | input | 1 | Asynchronous line being measured |
| i_ready | input | 1 | Consumer accepts the head entry |
| o_valid | output | 1 | A queued entry is presented |
| o_width | output | TS_W | Interval length in clock cycles |
| o_pol | output | 1 | Level held during the interval (1 = high) |
| o_overflow | output | 1 | Sticky flag: a width was dropped |

## Verification
The bench feeds runs of single-cycle intervals. A design that detected edges only every other cycle, or that stalled stage one while stage two worked, would merge or drop these intervals and produce wrong widths. Intervals longer than 256 cycles are sent to a second instance with an 8-bit counter: a non-modular subtraction there produces huge widths. With the consumer stalled, seventeen or more widths arrive. A queue that overwrote old entries, kept the extra one, or set the flag one entry early would show up either in the drained data or in the time at which the flag rises. The bench then checks that later traffic leaves the flag set and that reset clears it. It also checks that the very first transition after reset queues nothing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Level carried by a queued interval
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;

  // Modular interval between two timestamps of the given width
  function automatic logic [63:0] span_mod(input logic [63:0] now_ts,
                                           input logic [63:0] then_ts);
    return now_ts - then_ts;
  endfunction
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_edge_stage.sv
module pwm_edge_stage #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic [TS_W-1:0] tick,
  output logic            mark_q,
  output logic [TS_W-1:0] mark_ts_q,
  output logic            mark_lvl_q
);
  logic prev_lvl;

  // Stage 1: compare every cycle, register a marker plus its timestamp
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl   <= 1'b0;
      mark_q     <= 1'b0;
      mark_ts_q  <= '0;
      mark_lvl_q <= 1'b0;
    end else begin
      prev_lvl   <= lvl;
      mark_q     <= (lvl != prev_lvl);
      mark_ts_q  <= tick;
      mark_lvl_q <= prev_lvl;
    end
  end
endmodule

// File: rtl/pwm_width_stage.sv
module pwm_width_stage
  import pwm_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mark_q,
  input  logic [TS_W-1:0] mark_ts_q,
  input  logic            mark_lvl_q,
  output logic            push,
  output logic [TS_W-1:0] push_width,
  output lvl_e            push_lvl,
  output logic            armed
);
  logic [TS_W-1:0] last_ts;
  logic [63:0]     wide_now, wide_then, wide_diff;

  assign wide_now   = 64'(mark_ts_q);
  assign wide_then  = 64'(last_ts);
  assign wide_diff  = span_mod(wide_now, wide_then);
  assign push_width = wide_diff[TS_W-1:0];
  assign push_lvl   = lvl_e'(mark_lvl_q);
  assign push       = mark_q && armed;

  // Stage 2: the marker from last cycle drives subtraction and the queue write
  always_ff @(posedge clk) begin
    if (rst) begin
      last_ts <= '0;
      armed   <= 1'b0;
    end else if (mark_q) begin
      last_ts <= mark_ts_q;
      armed   <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_fifo.sv
module pwm_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_req,
  input  logic [W-1:0]             wr_data,
  output logic                     full,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [W-1:0]             rd_data,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign do_wr    = wr_req && !full;
  assign do_rd    = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import pwm_pkg::*;
#(
  parameter int TS_W        = 32,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_line,
  input  logic            i_ready,
  output logic            o_valid,
  output logic [TS_W-1:0] o_width,
  output logic            o_pol,
  output logic            o_overflow
);
  localparam int ENTRY_W = TS_W + 1;
  localparam int CW      = $clog2(DEPTH) + 1;

  logic [TS_W-1:0]    tick;
  logic               line_s;
  logic               mark_q, mark_lvl_q;
  logic [TS_W-1:0]    mark_ts_q;
  logic               push, armed;
  logic [TS_W-1:0]    push_width;
  lvl_e               push_lvl;
  logic               q_full;
  logic [ENTRY_W-1:0] head;
  logic [CW-1:0]      q_count;

  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else     tick <= tick + 1'b1;
  end

  pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(i_line), .q(line_s)
  );

  pwm_edge_stage #(.TS_W(TS_W)) u_edge (
    .clk(clk), .rst(rst), .lvl(line_s), .tick(tick),
    .mark_q(mark_q), .mark_ts_q(mark_ts_q), .mark_lvl_q(mark_lvl_q)
  );

  pwm_width_stage #(.TS_W(TS_W)) u_width (
    .clk(clk), .rst(rst), .mark_q(mark_q), .mark_ts_q(mark_ts_q),
    .mark_lvl_q(mark_lvl_q), .push(push), .push_width(push_width),
    .push_lvl(push_lvl), .armed(armed)
  );

  pwm_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_req(push), .wr_data({push_lvl, push_width}),
    .full(q_full), .rd_valid(o_valid), .rd_ready(i_ready),
    .rd_data(head), .count(q_count)
  );

  assign o_width = head[TS_W-1:0];
  assign o_pol   = head[TS_W];

  always_ff @(posedge clk) begin
    if (rst)                  o_overflow <= 1'b0;
    else if (push && q_full)  o_overflow <= 1'b1;
  end
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   i_ready,
  input logic                   o_valid,
  input logic [TS_W-1:0]        o_width,
  input logic                   o_pol,
  input logic                   o_overflow,
  input logic                   mark_q,
  input logic                   armed,
  input logic                   push,
  input logic                   q_full,
  input logic [$clog2(DEPTH):0] q_count
);
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    o_overflow |=> o_overflow);

  a_r8_head_held: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_width) && $stable(o_pol)));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (rst)
    q_count <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r9_flag_needs_drop: assert property (@(posedge clk) disable iff (rst)
    (!o_overflow ##1 o_overflow) |-> $past(push && q_full));

  a_r3_first_mark_silent: assert property (@(posedge clk) disable iff (rst)
    (mark_q && !armed) |=> (q_count <= $past(q_count)));
endmodule

bind pulse_width_meter pwm_checker #(.TS_W(TS_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .i_ready(i_ready), .o_valid(o_valid),
  .o_width(o_width), .o_pol(o_pol), .o_overflow(o_overflow),
  .mark_q(mark_q), .armed(armed), .push(push), .q_full(q_full),
  .q_count(q_count)
);

// File: tb/pulse_width_meter_tb_top.sv
module pulse_width_meter_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic rdy = 1'b0;

  logic        v32, p32, ov32;
  logic [31:0] w32;
  logic        v8, p8, ov8;
  logic [7:0]  w8;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_chg = 0;
  bit have_prev = 0;
  bit exp_ovf = 0;
  bit cur_lvl = 0;
  int exp_w[$];
  bit exp_p[$];

  always #2.5 clk = ~clk;

  pulse_width_meter dut_i (
    .clk(clk), .rst(rst), .i_line(line), .i_ready(rdy),
    .o_valid(v32), .o_width(w32), .o_pol(p32), .o_overflow(ov32)
  );

  pulse_width_meter #(.TS_W(8)) dut_w (
    .clk(clk), .rst(rst), .i_line(line), .i_ready(rdy),
    .o_valid(v8), .o_width(w8), .o_pol(p8), .o_overflow(ov8)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Reference model: record a level change and queue its interval
  task automatic hold(input bit v, input int n);
    if (v != cur_lvl) begin
      if (have_prev) begin
        if (exp_w.size() < DEPTH) begin
          exp_w.push_back(cyc - last_chg);
          exp_p.push_back(cur_lvl);
        end else exp_ovf = 1;
      end
      have_prev = 1;
      last_chg  = cyc;
      cur_lvl   = v;
    end
    line = v;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); cyc++; #1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); cyc++; #1;
    end
  endtask

  task automatic do_reset();
    line = 0; cur_lvl = 0; have_prev = 0; exp_ovf = 0;
    idle(4);
    rst = 1;
    idle(3);
    rst = 0;
    exp_w.delete(); exp_p.delete();
  endtask

  // Pop-side comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(v8 == v32, "R7 narrow instance valid lockstep", v8, v32);
      if (v32 && rdy) begin
        if (exp_w.size() == 0) chk(0, "R3/R8 unexpected entry", w32, -1);
        else begin
          int ew; bit ep;
          ew = exp_w.pop_front(); ep = exp_p.pop_front();
          chk(w32 == 32'(ew), "R4/R6 width", w32, ew);
          chk(p32 == ep, "R5 polarity", p32, ep);
          chk(w8 == 8'(ew), "R7 modular width", w8, ew % 256);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    idle(3);
    rst = 0;
    #1;
    @(negedge clk);
    chk(v32 == 0, "R2 valid after reset", v32, 0);
    chk(ov32 == 0, "R2 overflow after reset", ov32, 0);
    @(posedge clk); cyc++; #1;

    // Phase A: consumer always ready; first change queues nothing (R3), R1 start low
    rdy = 1;
    hold(0, 4);
    hold(1, 5); hold(0, 3); hold(1, 1); hold(0, 1); hold(1, 1);
    hold(0, 2); hold(1, 7); hold(0, 1); hold(1, 40); hold(0, 300);
    hold(1, 1); hold(0, 1); hold(1, 1); hold(0, 20);
    idle(10);
    chk(exp_w.size() == 0, "R4 all intervals delivered", exp_w.size(), 0);
    chk(v32 == 0, "R3 no extra entry", v32, 0);

    // Phase B: consumer stalls at random, head must be preserved (R8)
    for (int k = 0; k < 80; k++) begin
      rdy = ($urandom_range(3) != 0);
      hold(~cur_lvl, 2 + $urandom_range(5));
    end
    rdy = 1;
    idle(20);
    chk(exp_w.size() == 0, "R8 ordered drain after stalls", exp_w.size(), 0);

    // Phase C: fill the queue with the consumer stopped (R9)
    rdy = 0;
    for (int k = 0; k < 16; k++) hold(~cur_lvl, 3 + k);
    idle(8);
    chk(ov32 == 0, "R9 flag clear at exactly DEPTH", ov32, 0);
    hold(~cur_lvl, 4);
    hold(~cur_lvl, 4);
    hold(~cur_lvl, 6);
    idle(8);
    chk(ov32 == 1, "R9 flag set after drop", ov32, exp_ovf);
    rdy = 1;
    idle(30);
    chk(exp_w.size() == 0, "R9 oldest 16 kept", exp_w.size(), 0);
    hold(~cur_lvl, 5); hold(~cur_lvl, 5);
    idle(10);
    chk(ov32 == 1, "R10 flag stays after traffic", ov32, 1);

    // Reset clears the flag and rearms the first-change rule
    do_reset();
    @(negedge clk);
    chk(ov32 == 0, "R10 reset clears flag", ov32, 0);
    chk(v32 == 0, "R2 empty after reset", v32, 0);
    @(posedge clk); cyc++; #1;
    hold(1, 6); hold(0, 9); hold(1, 2);
    idle(10);
    chk(exp_w.size() == 0, "R3 rearmed after reset", exp_w.size(), 0);
    report();
  end
endmodule